// File: doc/BRIEF.md
# Sampled-Data Result Queue with Fill-Level Interrupt

This block sits between a multichannel converter and its host. Each conversion result arrives with a one-cycle done strobe and is queued in an eight-entry first-in first-out store. The host takes results from the head of the queue with a read strobe. An interrupt is raised as soon as the stored count reaches a programmed depth. That depth is a quarter, a half, three quarters or all of the store, or exactly one entry in single-shot mode.

A channel sequencer tells the converter which input to sample next. In fixed mode it always names one configured channel. In sweep mode it walks an ordered list of channels. The list restarts after as many entries as the effective interrupt depth, so each interrupt covers one full pass of the list. For example, the list 0,2,4,6 with a half-depth setting produces an interrupt after one pass.

A synchronous clear empties the queue, clears the sticky overflow flag and rewinds the sweep.

Top module: `sample_fifo_irq`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `level_o`=0, `full_o`=0), `irq_o`=0, `overflow_o`=0 and the sweep position is the first list entry.
- R2: Results leave in arrival order. While the queue is not empty, `rd_data_o` shows the oldest entry, and `rd_i` removes it at the next clock edge. A result and a read in the same cycle on a non-empty queue both take effect.
- R3: The queue holds at most 8 results. A result arriving while the queue is full is dropped, even if a read happens in that cycle. The drop sets `overflow_o`, which stays set until a clear.
- R4: A read strobe while the queue is empty has no effect. The level stays 0 and the queue stays empty.
- R5: With single-shot off, `depth_sel_i` values 0, 1, 2 and 3 set the interrupt depth to 2, 4, 6 and 8 entries.
- R6: `irq_o` is high whenever the stored count is at or above the effective depth. It therefore rises right after the clock edge that stores the result reaching the depth. It stays high until reads bring the count below the depth or a clear empties the queue.
- R7: With `single_shot_i`=1 the effective depth is one entry, whatever the value of `depth_sel_i`.
- R8: `fill_o` bit 0 is set at a count of 2 or more, bit 1 at 4 or more, bit 2 at 6 or more, and bit 3 at 8.
- R9: With `sweep_en_i`=0, `chan_o` equals `fixed_chan_i`.
- R10: With `sweep_en_i`=1, `chan_o` is list entry p, taken from `sweep_list_i` bits [3p+2:3p]. Every `conv_done_i` without a clear moves p to the next entry. After entry (effective depth − 1), p returns to 0.
- R11: `clear_i` empties the queue, clears `overflow_o` and sets the sweep position to 0 at the next edge. It overrides a result or a read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of queue, overflow and sweep position |
| conv_done_i | input | 1 | One-cycle strobe: a conversion result is valid |
| conv_data_i | input | 12 | Conversion result |
| depth_sel_i | input | 2 | Interrupt depth select (quarters of the store) |
| single_shot_i | input | 1 | Forces the interrupt depth to one entry |
| sweep_en_i | input | 1 | 1: channels follow the sweep list; 0: fixed channel |
| fixed_chan_i | input | 3 | Channel used in fixed mode |
| sweep_list_i | input | 24 | Eight 3-bit channel entries, entry p at bits [3p+2:3p] |
| rd_i | input | 1 | Host read strobe, pops the head entry |
| chan_o | output | 3 | Channel for the next conversion |
| rd_data_o | output | 12 | Oldest stored result |
| level_o | output | 4 | Number of stored results |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| fill_o | output | 4 | Quarter fill flags |
| irq_o | output | 1 | Fill-level interrupt |
| overflow_o | output | 1 | Sticky: a result was dropped while full |

## Verification
The assertions assume that the strobes are clean synchronous levels for one cycle each. They also assume that configuration changes happen only between clock edges, so that the depth used to wrap the sweep is the depth in force at that edge. The stimulus drives every input at the falling edge. It changes the configuration only between whole cycles, and it mixes reads with results, including reads on an empty queue and results arriving at a full queue. A clear is held for exactly one cycle and can coincide with both strobes.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned DEF_DATA_W   = 12;
  localparam int unsigned DEF_DEPTH    = 8;
  localparam int unsigned DEF_CHAN_W   = 3;
  localparam int unsigned DEF_LIST_LEN = 8;
  localparam int unsigned N_QUARTERS   = 4;

  // effective interrupt depth: one entry in single shot, else (sel+1) quarters
  function automatic int unsigned eff_depth(input logic single, input logic [1:0] sel,
                                            input int unsigned depth);
    if (single) return 1;
    return ((int'(sel) + 1) * depth) / N_QUARTERS;
  endfunction
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [LW-1:0]     level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overflow_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [LW-1:0]     cnt_q;
  logic              ovf_q;
  logic              push_ok, pop_ok;

  assign full_o     = (cnt_q == LW'(DEPTH));
  assign empty_o    = (cnt_q == '0);
  assign push_ok    = push_i & ~full_o;
  assign pop_ok     = pop_i & ~empty_o;
  assign head_o     = mem_q[rd_ptr_q];
  assign level_o    = cnt_q;
  assign overflow_o = ovf_q;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full_o) ovf_q <= 1'b1;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH)) else $error("level above depth"); // R3
  AST_DROP_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clear_i) |=> (full_o && overflow_o)) else $error("push into full"); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clear_i) |=> overflow_o) else $error("overflow lost"); // R3
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !clear_i) |=> empty_o) else $error("pop from empty"); // R4
  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (empty_o && !overflow_o)) else $error("clear incomplete"); // R11
endmodule

// File: rtl/sfifo_level_mon.sv
module sfifo_level_mon #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] thr_i,
  output logic [3:0]    fill_o,
  output logic          irq_o
);
  for (genvar q = 0; q < 4; q++) begin : g_quarter
    localparam int unsigned QLVL = ((q + 1) * DEPTH) / 4;
    assign fill_o[q] = (level_i >= LW'(QLVL));
  end

  assign irq_o = (level_i >= thr_i);

  AST_FULL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == LW'(DEPTH)) |-> irq_o) else $error("full without irq"); // R6
  AST_FLAGS_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o[3] |-> (fill_o[2] && fill_o[1] && fill_o[0])) else $error("flags not nested"); // R8
endmodule

// File: rtl/sfifo_chan_seq.sv
module sfifo_chan_seq #(
  parameter int unsigned CHAN_W   = 3,
  parameter int unsigned LIST_LEN = 8,
  parameter int unsigned LW       = 4,
  localparam int unsigned PW      = (LIST_LEN > 1) ? $clog2(LIST_LEN) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       step_i,
  input  logic                       sweep_en_i,
  input  logic [CHAN_W-1:0]          fixed_i,
  input  logic [LIST_LEN*CHAN_W-1:0] list_i,
  input  logic [LW-1:0]              wrap_len_i,
  output logic [CHAN_W-1:0]          chan_o
);
  logic [PW-1:0] ptr_q;
  logic [PW:0]   ptr_inc;
  logic          wrap;

  assign ptr_inc = {1'b0, ptr_q} + 1'b1;
  assign wrap    = (32'(ptr_inc) >= 32'(wrap_len_i)) || (ptr_q == PW'(LIST_LEN - 1));
  assign chan_o  = sweep_en_i ? list_i[ptr_q*CHAN_W +: CHAN_W] : fixed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clear_i) ptr_q <= '0;
    else if (step_i)  ptr_q <= wrap ? '0 : ptr_inc[PW-1:0];
  end

  AST_PTR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ptr_q == '0)) else $error("sweep not rewound"); // R11
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(ptr_q)) else $error("sweep moved without strobe"); // R10
endmodule

// File: rtl/sample_fifo_irq.sv
module sample_fifo_irq
  import sfifo_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned DEPTH    = DEF_DEPTH,
  parameter int unsigned CHAN_W   = DEF_CHAN_W,
  parameter int unsigned LIST_LEN = DEF_LIST_LEN,
  localparam int unsigned LW      = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       conv_done_i,
  input  logic [DATA_W-1:0]          conv_data_i,
  input  logic [1:0]                 depth_sel_i,
  input  logic                       single_shot_i,
  input  logic                       sweep_en_i,
  input  logic [CHAN_W-1:0]          fixed_chan_i,
  input  logic [LIST_LEN*CHAN_W-1:0] sweep_list_i,
  input  logic                       rd_i,
  output logic [CHAN_W-1:0]          chan_o,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic [LW-1:0]              level_o,
  output logic                       empty_o,
  output logic                       full_o,
  output logic [3:0]                 fill_o,
  output logic                       irq_o,
  output logic                       overflow_o
);
  logic [LW-1:0] thr;

  assign thr = LW'(eff_depth(single_shot_i, depth_sel_i, DEPTH));

  sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .push_i     (conv_done_i),
    .data_i     (conv_data_i),
    .pop_i      (rd_i),
    .head_o     (rd_data_o),
    .level_o    (level_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .overflow_o (overflow_o)
  );

  sfifo_level_mon #(.DEPTH(DEPTH)) i_level_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level_o),
    .thr_i   (thr),
    .fill_o  (fill_o),
    .irq_o   (irq_o)
  );

  sfifo_chan_seq #(.CHAN_W(CHAN_W), .LIST_LEN(LIST_LEN), .LW(LW)) i_chan_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .step_i     (conv_done_i),
    .sweep_en_i (sweep_en_i),
    .fixed_i    (fixed_chan_i),
    .list_i     (sweep_list_i),
    .wrap_len_i (thr),
    .chan_o     (chan_o)
  );

  AST_SINGLE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_shot_i && !empty_o) |-> irq_o) else $error("single shot irq missing"); // R7
endmodule

// File: tb/test_sample_fifo_irq.sv
module test_sample_fifo_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0, conv_done_i = 1'b0, rd_i = 1'b0;
  logic [11:0] conv_data_i = '0;
  logic [1:0]  depth_sel_i = '0;
  logic        single_shot_i = 1'b0, sweep_en_i = 1'b0;
  logic [2:0]  fixed_chan_i = 3'd5;
  logic [23:0] sweep_list_i = '0;
  logic [2:0]  chan_o;
  logic [11:0] rd_data_o;
  logic [3:0]  level_o, fill_o;
  logic        empty_o, full_o, irq_o, overflow_o;

  sample_fifo_irq i_sample_fifo_irq (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .conv_done_i(conv_done_i),
    .conv_data_i(conv_data_i), .depth_sel_i(depth_sel_i), .single_shot_i(single_shot_i),
    .sweep_en_i(sweep_en_i), .fixed_chan_i(fixed_chan_i), .sweep_list_i(sweep_list_i),
    .rd_i(rd_i), .chan_o(chan_o), .rd_data_o(rd_data_o), .level_o(level_o),
    .empty_o(empty_o), .full_o(full_o), .fill_o(fill_o), .irq_o(irq_o),
    .overflow_o(overflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int q[$];
  int ptr = 0;
  bit ovf = 0;
  bit done = 0;

  function automatic int m_thr();
    return single_shot_i ? 1 : 2 * (int'(depth_sel_i) + 1);
  endfunction

  function automatic int m_list(int p);
    return int'(sweep_list_i[p*3 +: 3]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int f;
    f = 0;
    if (q.size() >= 2) f |= 1;
    if (q.size() >= 4) f |= 2;
    if (q.size() >= 6) f |= 4;
    if (q.size() >= 8) f |= 8;
    chk("R3 level", int'(level_o), q.size());
    chk("R4 empty", int'(empty_o), int'(q.size() == 0));
    chk("R3 full", int'(full_o), int'(q.size() == 8));
    chk("R8 fill", int'(fill_o), f);
    if (single_shot_i) chk("R7 irq", int'(irq_o), int'(q.size() >= 1));
    else               chk("R5 irq", int'(irq_o), int'(q.size() >= m_thr()));
    chk("R3 overflow", int'(overflow_o), int'(ovf));
    if (q.size() > 0) chk("R2 head", int'(rd_data_o), q[0]);
    if (sweep_en_i) chk("R10 chan", int'(chan_o), m_list(ptr));
    else            chk("R9 chan", int'(chan_o), int'(fixed_chan_i));
  endtask

  task automatic model_step();
    bit was_full, was_empty;
    was_full  = (q.size() == 8);
    was_empty = (q.size() == 0);
    if (clear_i) begin
      q.delete(); ptr = 0; ovf = 0;
      return;
    end
    if (rd_i && !was_empty) void'(q.pop_front());
    if (conv_done_i) begin
      if (was_full) ovf = 1;
      else q.push_back(int'(conv_data_i));
      ptr = (ptr + 1 >= m_thr() || ptr == 7) ? 0 : ptr + 1;
    end
  endtask

  // drive at falling edge, let one rising edge pass, compare at next falling edge
  task automatic cyc(input bit c, input int d, input bit r, input bit cl);
    conv_done_i = c; conv_data_i = 12'(d); rd_i = r; clear_i = cl;
    model_step();
    @(posedge clk);
    @(negedge clk);
    conv_done_i = 0; rd_i = 0; clear_i = 0;
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", int'(level_o), 0);
    chk("R1 empty", int'(empty_o), 1);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 overflow", int'(overflow_o), 0);
    chk("R1 chan", int'(chan_o), 5);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 fixed channel, full depth, R6 irq at 8th result
    fixed_chan_i = 3'd3; depth_sel_i = 2'd3;
    for (int i = 0; i < 8; i++) begin
      cyc(1, 100 + i, 0, 0);
      chk("R9 fixed chan", int'(chan_o), 3);
      chk("R6 irq edge", int'(irq_o), int'(i == 7));
    end
    // R3 drop into full, even with a read in the same cycle
    cyc(1, 999, 0, 0);
    chk("R3 sticky ovf", int'(overflow_o), 1);
    cyc(1, 998, 1, 0);
    chk("R3 level after drop", int'(level_o), 7);
    // R2 order, R6 irq drops below depth
    for (int i = 0; i < 7; i++) begin
      chk("R2 order", int'(rd_data_o), 101 + i);
      cyc(0, 0, 1, 0);
      chk("R6 irq low", int'(irq_o), 0);
    end
    // R4 read on empty
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    chk("R4 stays empty", int'(level_o), 0);
    chk("R3 ovf held", int'(overflow_o), 1);
    cyc(0, 0, 0, 1);
    chk("R11 ovf cleared", int'(overflow_o), 0);

    // R10 sweep 0,2,4,6 with half depth
    sweep_list_i = {3'd6, 3'd4, 3'd2, 3'd0, 3'd6, 3'd4, 3'd2, 3'd0};
    sweep_en_i = 1; depth_sel_i = 2'd1;
    @(negedge clk);
    chk("R10 first entry", int'(chan_o), 0);
    for (int i = 0; i < 5; i++) begin
      cyc(1, 200 + i, 0, 0);
      chk("R10 sweep chan", int'(chan_o), ((i + 1) % 4) * 2);
      if (i == 3) chk("R6 irq half", int'(irq_o), 1);
      if (i == 2) chk("R5 irq not yet", int'(irq_o), 0);
    end
    // R11 clear overrides conv and rd
    cyc(1, 7, 1, 1);
    chk("R11 level", int'(level_o), 0);
    chk("R11 sweep rewind", int'(chan_o), 0);

    // R7 single shot ignores depth select
    single_shot_i = 1; depth_sel_i = 2'd3;
    cyc(1, 55, 0, 0);
    chk("R7 irq at one", int'(irq_o), 1);
    chk("R7 sweep len one", int'(chan_o), 0);
    cyc(0, 0, 1, 0);
    chk("R7 irq off", int'(irq_o), 0);
    single_shot_i = 0;
    cyc(0, 0, 0, 1);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 60 == 0) begin
        depth_sel_i   = 2'($urandom_range(0, 3));
        single_shot_i = ($urandom_range(0, 5) == 0);
        sweep_en_i    = 1'($urandom_range(0, 1));
        fixed_chan_i  = 3'($urandom_range(0, 7));
        sweep_list_i  = 24'($urandom);
      end
      cyc(($urandom_range(0, 9) < ((n / 500) % 2 ? 7 : 4)), int'($urandom_range(0, 4095)),
          ($urandom_range(0, 9) < ((n / 500) % 2 ? 3 : 6)), ($urandom_range(0, 199) == 0));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule